// File: doc/BRIEF.md
# Shared Two-Channel Timer Prescaler

This block produces the count enables for two timer channels. One free-running 10-bit divider is shared by both channels. Each channel has its own 3-bit clock-select code. The code picks one source: stopped, every system clock cycle, one of four divider taps, or an edge on that channel's external pin. The result is a single-cycle tick in the system clock domain. A timer counter that sits outside this block advances on the cycle after a tick.

The divider never stops, whatever codes are selected. Because both channels share it, a prescaler-clear strobe moves the tap phase of both channels together. Each external pin goes through a half-cycle capture stage on the falling clock edge, then a rising-edge register, then an edge detector. The polarity of the edge is set by the channel's code.

The block has no streaming data path, so no valid/ready handshake applies. Every pin is a plain control level or a pulse.

Top module: `tmr_prescaler`

## Requirements
- R1: Code 0 stops the channel. Its tick stays low whatever the divider or the channel's pin does.
- R2: Code 1 gives a tick on every cycle.
- R3: Codes 2, 3, 4 and 5 select divisors 8, 64, 256 and 1024. A tick comes on the cycle when the low log2(N) bits of the divider wrap to zero. After a clear, the first tick is seen N cycles later, and then one tick comes every N cycles.
- R4: The divider counts up by one on every cycle that is not a clear, whatever either code is set to. When a channel is switched from code 0 to a tap code, its first tick comes within 1 to N+1 cycles.
- R5: A prescaler-clear strobe sets the divider to zero on the next edge. This restarts the tap phase of both channels at once.
- R6: Code 7 gives exactly one tick for each rising pin edge, and code 6 gives exactly one tick for each falling pin edge. The other edge gives none. A pin change made just after rising clock edge E shows as a tick in the cycle that follows edge E+2.
- R7: Reset is synchronous. It drives both ticks low. A pin that is held at a steady level through reset gives no tick after reset.
- R8: Ticks are registered. A code change takes effect from the next edge, and the switch itself never creates a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| presc_clr_i | input | 1 | Clears the shared divider |
| pin_a_i | input | 1 | External count pin, channel A |
| pin_b_i | input | 1 | External count pin, channel B |
| cs_a_i | input | 3 | Clock-select code, channel A |
| cs_b_i | input | 3 | Clock-select code, channel B |
| tick_a_o | output | 1 | Count enable, channel A |
| tick_b_o | output | 1 | Count enable, channel B |

## Verification
The assertions check on every cycle that the divider increments or clears, that code 0 stops a tick and code 1 forces one, and that the 8 and 1024 taps line up with the divider wrap. Some behaviour can only be shown by the bench's scenarios:
- the pin latency and edge polarity;
- the missing false edge after reset;
- the 1 to N+1 first-tick window;
- a second clear that moves both channels' phase partway through a period.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 4;

  localparam logic [SEL_W-1:0] SRC_OFF   = 3'd0;
  localparam logic [SEL_W-1:0] SRC_SYS   = 3'd1;
  localparam logic [SEL_W-1:0] SRC_D8    = 3'd2;
  localparam logic [SEL_W-1:0] SRC_D64   = 3'd3;
  localparam logic [SEL_W-1:0] SRC_D256  = 3'd4;
  localparam logic [SEL_W-1:0] SRC_D1024 = 3'd5;
  localparam logic [SEL_W-1:0] SRC_FALL  = 3'd6;
  localparam logic [SEL_W-1:0] SRC_RISE  = 3'd7;

  // number of low divider bits that must wrap for tap idx
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/presc_divider.sv
module presc_divider
  import tmr_presc_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                clr_i,
  output logic [DIV_W-1:0]    cnt_o,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int LB = tap_log2(g);
    // all ones now means the low LB bits wrap to zero on this edge
    assign tap_o[g] = &cnt_q[LB-1:0];
  end
endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic half_q;
  logic sync_q;
  logic prev_q;

  // half-cycle stage: holds the pin level seen while the clock was high
  always_ff @(negedge clk_i) half_q <= pin_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= half_q;
      prev_q <= half_q;
    end else begin
      sync_q <= half_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o =  sync_q & ~prev_q;
  assign fall_o = ~sync_q &  prev_q;
endmodule

// File: rtl/chan_select.sv
module chan_select
  import tmr_presc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [SEL_W-1:0]    cs_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);
  logic src_d;
  logic tick_q;

  always_comb begin
    case (cs_i)
      SRC_OFF:   src_d = 1'b0;
      SRC_SYS:   src_d = 1'b1;
      SRC_D8:    src_d = tap_i[0];
      SRC_D64:   src_d = tap_i[1];
      SRC_D256:  src_d = tap_i[2];
      SRC_D1024: src_d = tap_i[3];
      SRC_FALL:  src_d = fall_i;
      default:   src_d = rise_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_q <= 1'b0;
    else       tick_q <= src_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_presc_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             presc_clr_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic [SEL_W-1:0] cs_a_i,
  input  logic [SEL_W-1:0] cs_b_i,
  output logic             tick_a_o,
  output logic             tick_b_o
);
  localparam int NUM_CH = 2;

  logic [DIV_W-1:0]    div_cnt;
  logic [NUM_TAPS-1:0] taps;
  logic [NUM_CH-1:0]   pins;
  logic [NUM_CH-1:0]   ticks;
  logic [SEL_W-1:0]    sel [NUM_CH];

  assign pins   = {pin_b_i, pin_a_i};
  assign sel[0] = cs_a_i;
  assign sel[1] = cs_b_i;

  presc_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (presc_clr_i),
    .cnt_o (div_cnt),
    .tap_o (taps)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rise;
    logic fall;

    pin_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .pin_i  (pins[c]),
      .rise_o (rise),
      .fall_o (fall)
    );

    chan_select u_sel (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .cs_i   (sel[c]),
      .tap_i  (taps),
      .rise_i (rise),
      .fall_i (fall),
      .tick_o (ticks[c])
    );
  end

  assign tick_a_o = ticks[0];
  assign tick_b_o = ticks[1];
endmodule

// File: rtl/tmr_prescaler_chk.sv
module tmr_prescaler_chk
  import tmr_presc_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             presc_clr_i,
  input logic [SEL_W-1:0] cs_a_i,
  input logic [SEL_W-1:0] cs_b_i,
  input logic             tick_a_o,
  input logic             tick_b_o,
  input logic [DIV_W-1:0] div_cnt
);
  localparam int LB_MIN = tap_log2(0);
  localparam int LB_MAX = tap_log2(NUM_TAPS-1);

  // R1
  stop_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_a_i == SRC_OFF) |=> !tick_a_o);
  // R1
  stop_b_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_b_i == SRC_OFF) |=> !tick_b_o);
  // R2
  sys_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_a_i == SRC_SYS) |=> tick_a_o);
  // R3
  tap8_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_a_i == SRC_D8 && (&div_cnt[LB_MIN-1:0])) |=> tick_a_o);
  // R3
  tap1024_b_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_b_i == SRC_D1024 && !(&div_cnt[LB_MAX-1:0])) |=> !tick_b_o);
  // R4
  free_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !presc_clr_i |=> (div_cnt == DIV_W'($past(div_cnt) + 1'b1)));
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    presc_clr_i |=> (div_cnt == '0));
endmodule

bind tmr_prescaler tmr_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .presc_clr_i (presc_clr_i),
  .cs_a_i      (cs_a_i),
  .cs_b_i      (cs_b_i),
  .tick_a_o    (tick_a_o),
  .tick_b_o    (tick_b_o),
  .div_cnt     (div_cnt)
);

// File: tb/tmr_prescaler_bench.sv
module tmr_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       pin_a = 1'b1;
  logic       pin_b = 1'b0;
  logic [2:0] cs_a = 3'd7;
  logic [2:0] cs_b = 3'd6;
  logic       tick_a;
  logic       tick_b;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_prescaler u_tmr_prescaler (
    .clk_i(clk), .rst_i(rst), .presc_clr_i(clr),
    .pin_a_i(pin_a), .pin_b_i(pin_b),
    .cs_a_i(cs_a), .cs_b_i(cs_b),
    .tick_a_o(tick_a), .tick_b_o(tick_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      report();
      $finish;
    end
  end

  // {cs_a, cs_b, cycles, ticks expected on A, ticks expected on B}
  localparam logic [53:0] VEC [6] = '{
    {3'd0, 3'd1, 16'd20,   16'd0,  16'd20},
    {3'd1, 3'd2, 16'd64,   16'd64, 16'd8},
    {3'd2, 3'd3, 16'd128,  16'd16, 16'd2},
    {3'd4, 3'd5, 16'd1024, 16'd4,  16'd1},
    {3'd3, 3'd0, 16'd64,   16'd1,  16'd0},
    {3'd6, 3'd7, 16'd30,   16'd0,  16'd0}
  };

  initial begin
    int ca;
    int cb;
    int first;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R7: steady pin level through reset, no false edge afterwards
    ca = 0;
    cb = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #2;
      ca += tick_a;
      cb += tick_b;
    end
    check("R7 tick A after reset", ca, 0);
    check("R7 tick B after reset", cb, 0);

    // table walk: clear then count ticks (R1 R2 R3 R5 R6)
    for (int v = 0; v < 6; v++) begin
      @(posedge clk); #1;
      cs_a = VEC[v][53:51];
      cs_b = VEC[v][50:48];
      clr = 1'b1;
      @(posedge clk); #1 clr = 1'b0;
      ca = 0;
      cb = 0;
      for (int k = 1; k <= int'(VEC[v][47:32]); k++) begin
        @(posedge clk); #2;
        ca += tick_a;
        cb += tick_b;
      end
      check($sformatf("R3 vec%0d A cs=%0d", v, VEC[v][53:51]), ca, int'(VEC[v][31:16]));
      check($sformatf("R3 vec%0d B cs=%0d", v, VEC[v][50:48]), cb, int'(VEC[v][15:0]));
    end

    // R5: a second clear mid-period moves both channels' phase
    @(posedge clk); #1;
    cs_a = 3'd2; cs_b = 3'd3; clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
    ca = 0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); #2; ca += tick_a;
    end
    check("R5 no tick before second clear", ca, 0);
    clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); #2;
      check($sformatf("R5 A k=%0d", k), int'(tick_a), (k == 8) ? 1 : 0);
      check($sformatf("R5 B k=%0d", k), int'(tick_b), 0);
    end

    // R4: enable from stop at an arbitrary phase, first tick within 1..N+1
    cs_a = 3'd0; cs_b = 3'd0;
    repeat (3) @(posedge clk);
    #1 cs_a = 3'd2;
    first = 0;
    for (int k = 1; k <= 20 && first == 0; k++) begin
      @(posedge clk); #2;
      if (tick_a) first = k;
    end
    check("R4 first tick in window", int'(first >= 1 && first <= 9), 1);

    // R8: switching 1 -> 0 and 0 -> 1 takes effect next edge
    @(posedge clk); #1 cs_a = 3'd1;
    @(posedge clk); #2;
    check("R8 code1 active", int'(tick_a), 1);
    @(posedge clk); #1 cs_a = 3'd0;
    #1 check("R8 before switch edge", int'(tick_a), 1);
    @(posedge clk); #2;
    check("R8 after switch to stop", int'(tick_a), 0);

    // R6: rising on A (code 7), falling on B (code 6)
    cs_a = 3'd7; cs_b = 3'd6;
    @(posedge clk); #1 pin_a = 1'b0; pin_b = 1'b1;
    repeat (5) @(posedge clk);
    #1 pin_a = 1'b1; pin_b = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #2;
      check($sformatf("R6 rise A k=%0d", k), int'(tick_a), (k == 2) ? 1 : 0);
      check($sformatf("R6 fall B k=%0d", k), int'(tick_b), (k == 2) ? 1 : 0);
    end
    @(posedge clk); #1 pin_a = 1'b0; pin_b = 1'b1;
    ca = 0; cb = 0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #2; ca += tick_a; cb += tick_b;
    end
    check("R6 falling edge ignored on code 7", ca, 0);
    check("R6 rising edge ignored on code 6", cb, 0);

    // R1: pin toggles with code 0 give nothing
    @(posedge clk); #1 cs_a = 3'd0;
    ca = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); #1 pin_a = ~pin_a;
      #1 ca += tick_a;
    end
    repeat (3) begin
      @(posedge clk); #2 ca += tick_a;
    end
    check("R1 pin ignored when stopped", ca, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule